// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse Width Modulator

This block produces one pulse-width-modulated output from the core clock. A programmable divider turns the core clock into a slower PWM tick. A period counter steps once per tick and wraps after a programmed number of ticks. The output is high while the counter sits below a programmed high-time value. A separate override flag forces the output high for the whole period.

Software programs three settings through a small synchronous write port: the period, the high time together with the override flag, and the divider. Each written value first lands in a staging register. It is copied into the working set only on the tick that closes an output period, so one period never runs on a mix of old and new settings. A period setting of zero gives a constant level instead of a waveform.

Top module: `pwmg_top`

## Requirements
- R1: Synchronous active-high reset sets period 4, high time 0, override 0 and divider 0. The output is low after reset, and the first period boundary falls 5 core cycles after reset is released.
- R2: A write with select 0 stores wr_data[9:0] as the period. Select 1 stores wr_data[9:0] as the high time and wr_data[10] as the override flag. Select 2 stores wr_data[5:0] as the divider. All other data bits, and writes with select 3, have no effect.
- R3: With divider value N, one PWM tick occurs every N+1 core cycles (N = 0 ticks every cycle; N = 63 every 64 cycles).
- R4: With a nonzero period value P, one output period lasts P+1 ticks, and the counter runs 0..P.
- R5: With the override clear and P nonzero, the output is high during ticks whose counter value is below the high time and low for the others. A high time above P keeps the output high for the whole period.
- R6: With the override set and P nonzero, the output is high for the whole period, whatever the high time.
- R7: With P = 0, the output is constantly high, except as stated in R8.
- R8: With the override clear and high time 0, the output is constantly low for any period value, including 0.
- R9: Staged values enter the working set only on the tick that ends a period. A write made mid-period has no effect on that period. A write completed 4 core cycles before the period's last cycle takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Selects which setting the write targets |
| wr_data | input | 16 | Write data; only the bits named in R2 are used |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a complete new configuration written inside a running period, with its last field landing exactly four core cycles before that period's final cycle. The old settings must still run to the end of that period, and the new ones must start on the very next cycle. The stimulus resets the block and programs a first configuration during the default 5-cycle period. It then counts cycles to the second period of that configuration and places the three writes of a second configuration at 6, 5 and 4 cycles before its end. The expected waveform, tick by tick, is queued ahead of time and compared every cycle. Configurations are chosen to cover a zero period, a high time above the period, the override flag and the largest divider.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

    localparam int PER_W    = 10;
    localparam int PSC_W    = 6;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 2;
    localparam int FULL_BIT = PER_W;

    localparam logic [PER_W-1:0] PER_RST = PER_W'(4);

    typedef enum logic [SEL_W-1:0] {
        SEL_PERIOD = 2'd0,
        SEL_HIGH   = 2'd1,
        SEL_DIV    = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] high;
        logic             full;
        logic [PSC_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RST = '{period: PER_RST, high: '0, full: 1'b0, div: '0};

    function automatic logic wave_level(cfg_t c, logic [PER_W-1:0] cnt);
        logic lvl;
        if (c.period == '0)
            lvl = c.full || (c.high != '0);
        else if (c.full)
            lvl = 1'b1;
        else
            lvl = (cnt < c.high);
        return lvl;
    endfunction

endpackage

// File: rtl/pwmg_cfg_regs.sv
module pwmg_cfg_regs
    import pwmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output cfg_t              work
);

    cfg_t stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= CFG_RST;
            work  <= CFG_RST;
        end else begin
            if (wr_en) begin
                case (sel_e'(wr_sel))
                    SEL_PERIOD: stage.period <= wr_data[PER_W-1:0];
                    SEL_HIGH: begin
                        stage.high <= wr_data[PER_W-1:0];
                        stage.full <= wr_data[FULL_BIT];
                    end
                    SEL_DIV:    stage.div <= wr_data[PSC_W-1:0];
                    default:    ;
                endcase
            end
            if (load)
                work <= stage;
        end
    end

    // R9: working set only moves on a period boundary
    p_work_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(work));

    // R2: period field captured from the low data bits
    p_stage_period_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_PERIOD) |=> stage.period == $past(wr_data[PER_W-1:0]));

    // R2: select 3 leaves staging untouched
    p_stage_none_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE) |=> $stable(stage));

endmodule

// File: rtl/pwmg_prescaler.sv
module pwmg_prescaler
    import pwmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt;

    assign tick = (pcnt == div);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PSC_W'(1);
    end

    // R3: divider count never passes the working divider
    p_pcnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        pcnt <= div);

    // R3: a nonzero divider leaves a gap after each tick
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/pwmg_period_ctr.sv
module pwmg_period_ctr
    import pwmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = tick && (cnt == period);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + PER_W'(1);
    end

    // R4: counter stays within 0..P
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= period);

    // R4: counter steps by one on a non-final tick
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != period) |=> cnt == $past(cnt) + PER_W'(1));

    // R3: no tick, no count change
    p_cnt_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pwmg_wave.sv
module pwmg_wave
    import pwmg_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [PER_W-1:0] cnt,
    output logic             level
);

    always_comb begin
        level = wave_level(cfg, cnt);
    end

endmodule

// File: rtl/pwmg_top.sv
module pwmg_top
    import pwmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    cfg_t             work;
    logic             tick;
    logic             wrap;
    logic [PER_W-1:0] cnt;

    pwmg_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (wrap),
        .work    (work)
    );

    pwmg_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .div  (work.div),
        .tick (tick)
    );

    pwmg_period_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .period (work.period),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    pwmg_wave u_wave (
        .cfg   (work),
        .cnt   (cnt),
        .level (pwm_out)
    );

    // R6: override drives the output high
    p_full_high_r6: assert property (@(posedge clk) disable iff (rst)
        work.full |-> pwm_out);

    // R8: zero high time without override keeps output low
    p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!work.full && work.high == '0) |-> !pwm_out);

    // R7: zero period with any nonzero setting holds output high and steady
    p_per0_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (work.period == '0 && (work.full || work.high != '0) && !wrap) |=> pwm_out);

    // R5: output can only fall when the counter reaches the high time
    p_fall_point_r5: assert property (@(posedge clk) disable iff (rst)
        (work.period != '0 && !work.full && !wrap && $fell(pwm_out)) |-> cnt == work.high);

endmodule

// File: tb/sim_pwmg_top.sv
module sim_pwmg_top;
    import pwmg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              pwm_out;

    always #10 clk = ~clk;

    pwmg_top u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    typedef struct {
        int p;
        int d;
        int f;
        int s;
    } tcfg_t;

    bit    exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic bit ref_level(tcfg_t c, int k);
        if (c.p == 0) return (c.f != 0) || (c.d != 0);
        if (c.f != 0) return 1'b1;
        return k < c.d;
    endfunction

    task automatic push_period(tcfg_t c, string tag);
        for (int k = 0; k <= c.p; k++)
            for (int r = 0; r <= c.s; r++) begin
                exp_q.push_back(ref_level(c, k));
                tag_q.push_back(tag);
            end
    endtask

    // monitor: compare one queued level per cycle, away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (pwm_out !== e) begin
                n_bad++;
                $display("FAIL %s: pwm_out=%0b expected %0b", t, pwm_out, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [SEL_W-1:0] sel, logic [DATA_W-1:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic write_cfg(tcfg_t c, logic [DATA_W-1:0] rsv);
        wr(SEL_PERIOD, (rsv & 16'hFC00) | DATA_W'(c.p));
        wr(SEL_HIGH,   (rsv & 16'hF800) | (DATA_W'(c.f) << FULL_BIT) | DATA_W'(c.d));
        wr(SEL_DIV,    (rsv & 16'hFFC0) | DATA_W'(c.s));
    endtask

    task automatic run_case(tcfg_t a, tcfg_t b, logic [DATA_W-1:0] rsv,
                            string ta, string tb);
        int la;
        la = (a.p + 1) * (a.s + 1);
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        // R1: default period 4, high time 0 -> 5 low cycles
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(1'b0);
            tag_q.push_back("R1 reset default low");
        end
        push_period(a, ta);
        push_period(a, {"R9 mid-period write ignored, ", ta});
        push_period(b, tb);
        push_period(b, tb);
        write_cfg(a, rsv);                 // cycles 0..2
        wr(SEL_NONE, 16'hFFFF);            // cycle 3, R2 select 3 ignored
        // advance to cycle 2*la-2, inside the second period of a
        repeat (2 * la - 2 - 4) step();
        write_cfg(b, rsv);                 // last write 4 cycles before end
        while (exp_q.size() > 0) step();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        run_case('{10, 6, 0, 0}, '{3, 1, 0, 1}, 16'hFC00,
                 "R2 R4 R5 period10 high6", "R3 R9 new cfg after boundary");
        run_case('{5, 9, 0, 2}, '{7, 2, 1, 0}, 16'hA5C0,
                 "R3 R5 high above period", "R6 override high");
        run_case('{0, 0, 0, 7}, '{0, 3, 0, 7}, 16'h0000,
                 "R7 R8 period0 all zero low", "R7 period0 high");
        run_case('{0, 0, 1, 9}, '{6, 6, 0, 0}, 16'hF800,
                 "R7 period0 override high", "R4 R5 period6 high6");
        run_case('{4, 0, 0, 1}, '{2, 2, 0, 0}, 16'h5400,
                 "R8 high0 low", "R5 high equals period");
        run_case('{2, 1, 0, 63}, '{1, 1, 0, 0}, 16'hFFC0,
                 "R3 max divider", "R4 R5 period1 high1");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule